// File: doc/BRIEF.md
# Chip-Select Wake and Power-Down Sequencer

This block decides when the digital core of a low-power radio chip has power and a running oscillator. The host wakes the chip by pulling the active-low chip select low. The sequencer then turns on the core regulator and the oscillator enable and holds the serial data-out line high. When a fixed number of clock cycles has passed (a stand-in for oscillator start-up), it drives that line low. A low line tells the host that the core is ready and that serial clocking may begin.

Shutdown takes two steps. A power-down strobe from the command decoder only arms the shutdown. Power is removed when chip select next returns high. In that first powered-down cycle the block emits a one-cycle sleep pulse, so that neighbouring blocks can discard the volatile state they lose in sleep, such as the upper entries of an output-power table. A later chip-select low starts a full wake sequence again. The serial data-out line is released whenever chip select is high.

Top module: `csel_power_seq`

## Requirements
- R1: While reset is asserted, and afterwards until chip select falls, `reg_en`, `osc_en`, `so_oe` and `sleep_pulse` are all 0.
- R2: When `cs_n` is sampled low at a clock edge while the block is powered down, having been high at the previous edge, `reg_en` and `osc_en` are both 1 from that edge on.
- R3: During the wake period, whenever `cs_n` is low, `so_oe` is 1 and `so_o` is 1 (not ready).
- R4: The wake period lasts exactly `WAKE_CYCLES` clock cycles. From the following cycle on, `so_o` is 0 (ready) whenever `cs_n` is low.
- R5: When `cs_n` rises with no strobe armed, the core stays powered. A later `cs_n` low shows the ready level at once, with no new wake period.
- R6: A `pd_strobe` sampled at an edge while the core is ready and `cs_n` is low arms the shutdown. Power stays on while `cs_n` stays low, and `reg_en` and `osc_en` fall at the first edge at which `cs_n` is sampled high.
- R7: Further strobes while the shutdown is armed change neither the timing of the shutdown nor the sleep pulse.
- R8: `sleep_pulse` is 1 for exactly one cycle: the first cycle in which `reg_en` and `osc_en` are 0 after an armed shutdown.
- R9: Whenever `cs_n` is high, `so_oe` is 0, so the data-out line is high-impedance.
- R10: After a shutdown, a new `cs_n` falling edge restores `reg_en` and `osc_en` and runs a full wake period of `WAKE_CYCLES` cycles before the ready level appears.
- R11: A strobe received during the wake period, or while `cs_n` is high, is ignored, and the core stays powered when `cs_n` later rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select, already synchronous to `clk` |
| pd_strobe | input | 1 | One-cycle power-down command from the command decoder |
| reg_en | output | 1 | Core regulator enable |
| osc_en | output | 1 | Oscillator enable |
| so_o | output | 1 | Data-out level: 1 while waking, 0 when ready |
| so_oe | output | 1 | Data-out drive enable; 0 means high-impedance |
| sleep_pulse | output | 1 | One-cycle pulse on entry to power-down |

## Verification
The hardest case to reach is a shutdown that is armed and then held. The strobe has to arrive while the core is ready and chip select is still low, sometimes more than once. Chip select then has to stay low for a varying number of cycles before it rises. The bench sweeps the hold length against the number of repeated strobes. After each shutdown it starts a fresh wake, so every exit from the armed state, and the wake that follows it, is observed at the ports. A bench-side model computes the expected levels cycle by cycle.

// File: rtl/csel_power_pkg.sv
package csel_power_pkg;

  typedef enum logic [1:0] {
    PS_OFF    = 2'd0,
    PS_WAKING = 2'd1,
    PS_ACTIVE = 2'd2,
    PS_ARMED  = 2'd3
  } pwr_state_t;

  // True when a wake counter value marks the final cycle of a wake period
  function automatic logic wake_is_last(input int unsigned cnt, input int unsigned lim);
    return (cnt + 1) >= lim;
  endfunction

  // Core is powered in every state except OFF
  function automatic logic state_powered(input pwr_state_t s);
    return s != PS_OFF;
  endfunction

  // Ready level on data-out: low once the core has finished waking
  function automatic logic state_ready(input pwr_state_t s);
    return (s == PS_ACTIVE) || (s == PS_ARMED);
  endfunction

endpackage

// File: rtl/csel_edge.sv
module csel_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  output logic cs_fall
);
  logic cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_q <= 1'b1;
    else        cs_q <= cs_n;
  end

  assign cs_fall = cs_q & ~cs_n;
endmodule

// File: rtl/csel_wake_timer.sv
module csel_wake_timer #(
  parameter int unsigned WAKE_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic done
);
  import csel_power_pkg::*;

  localparam int unsigned CW = (WAKE_CYCLES > 1) ? $clog2(WAKE_CYCLES) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (start) cnt <= '0;
    else if (run)   cnt <= cnt + 1'b1;
  end

  assign done = run & wake_is_last(32'(cnt), WAKE_CYCLES);
endmodule

// File: rtl/csel_power_seq.sv
module csel_power_seq #(
  parameter int unsigned WAKE_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic pd_strobe,
  output logic reg_en,
  output logic osc_en,
  output logic so_o,
  output logic so_oe,
  output logic sleep_pulse
);
  import csel_power_pkg::*;

  pwr_state_t state, state_nx;
  logic cs_fall;
  logic waking;
  logic wake_start;
  logic wake_done;
  logic arm_evt;
  logic off_evt;

  csel_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .cs_fall (cs_fall)
  );

  assign waking     = (state == PS_WAKING);
  assign wake_start = (state == PS_OFF) & cs_fall;
  assign arm_evt    = (state == PS_ACTIVE) & ~cs_n & pd_strobe;
  assign off_evt    = (state == PS_ARMED) & cs_n;

  csel_wake_timer #(.WAKE_CYCLES(WAKE_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (wake_start),
    .run   (waking),
    .done  (wake_done)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      PS_OFF:    if (wake_start) state_nx = PS_WAKING;
      PS_WAKING: if (wake_done)  state_nx = PS_ACTIVE;
      PS_ACTIVE: if (arm_evt)    state_nx = PS_ARMED;
      PS_ARMED:  if (off_evt)    state_nx = PS_OFF;
      default:                   state_nx = PS_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= PS_OFF;
      sleep_pulse <= 1'b0;
    end else begin
      state       <= state_nx;
      sleep_pulse <= off_evt;
    end
  end

  assign reg_en = state_powered(state);
  assign osc_en = state_powered(state);
  assign so_oe  = ~cs_n;
  assign so_o   = ~state_ready(state);
endmodule

// File: rtl/csel_power_seq_chk.sv
module csel_power_seq_chk #(
  parameter int unsigned WAKE_CYCLES = 16
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic reg_en,
  input logic osc_en,
  input logic so_o,
  input logic so_oe,
  input logic sleep_pulse,
  input logic waking,
  input logic wake_done
);
  int unsigned wcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wcnt <= 0;
    else if (waking) wcnt <= wcnt + 1;
    else             wcnt <= 0;
  end

  // R8
  sleep_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_pulse |=> !sleep_pulse);

  // R8
  sleep_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_pulse |-> (!reg_en && !osc_en));

  // R6
  power_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reg_en) |-> (sleep_pulse && $past(cs_n)));

  // R2
  power_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_en) |-> ($past(!cs_n) && osc_en));

  // R4
  wake_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_done |-> (wcnt == WAKE_CYCLES - 1));

  // R3
  ready_powered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (so_oe && !so_o) |-> (reg_en && !waking));
endmodule

bind csel_power_seq csel_power_seq_chk #(.WAKE_CYCLES(WAKE_CYCLES)) u_chk (.*);

// File: tb/csel_power_seq_bench.sv
`timescale 1ns/1ps
module csel_power_seq_bench;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic pd_strobe = 1'b0;
  logic reg_en, osc_en, so_o, so_oe, sleep_pulse;

  int checks = 0;
  int errors = 0;

  // model: 0 off, 1 waking, 2 ready, 3 armed
  int mst = 0;
  int mcnt = 0;
  logic mprev = 1'b1;
  logic msleep = 1'b0;

  always #2 clk = ~clk;

  csel_power_seq #(.WAKE_CYCLES(W)) u_csel_power_seq (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .pd_strobe(pd_strobe),
    .reg_en(reg_en), .osc_en(osc_en), .so_o(so_o), .so_oe(so_oe),
    .sleep_pulse(sleep_pulse)
  );

  task automatic cmp(input string tag, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %0b exp %0b", tag, what, got, exp);
    end
  endtask

  task automatic check_all(input string tag);
    cmp(tag, "reg_en", reg_en, mst != 0);
    cmp(tag, "osc_en", osc_en, mst != 0);
    cmp(tag, "so_oe", so_oe, !cs_n);
    if (!cs_n) cmp(tag, "so_o", so_o, !(mst == 2 || mst == 3));
    cmp(tag, "sleep_pulse", sleep_pulse, msleep);
  endtask

  task automatic cyc(input logic cs, input logic stb, input string tag);
    int old;
    cs_n = cs;
    pd_strobe = stb;
    old = mst;
    msleep = (old == 3) && cs;
    case (old)
      0: if (!cs && mprev) begin mst = 1; mcnt = 0; end
      1: if (mcnt == W - 1) mst = 2; else mcnt++;
      2: if (!cs && stb) mst = 3;
      3: if (cs) mst = 0;
      default: mst = 0;
    endcase
    mprev = cs;
    @(posedge clk);
    #1;
    check_all(tag);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check_all("R1");
    rst_n = 1'b1;
    repeat (3) cyc(1'b1, 1'b0, "R1");

    // wake: first edge powers up, then W cycles high, then ready
    cyc(1'b0, 1'b0, "R2");
    for (int i = 0; i < W - 1; i++) cyc(1'b0, 1'b0, "R3");
    cyc(1'b0, 1'b0, "R4");
    cyc(1'b0, 1'b0, "R4");

    // chip select high with nothing armed
    repeat (4) cyc(1'b1, 1'b0, "R9");
    cyc(1'b1, 1'b0, "R5");
    cyc(1'b0, 1'b0, "R5");
    cmp("R5", "ready at once", so_o, 1'b0);

    // sweep: hold length vs number of repeated strobes
    for (int hold = 0; hold < 4; hold++) begin
      for (int reps = 1; reps <= 3; reps++) begin
        cyc(1'b0, 1'b1, "R6");
        for (int k = 1; k < reps; k++) cyc(1'b0, 1'b1, "R7");
        for (int k = 0; k < hold; k++) cyc(1'b0, 1'b0, "R6");
        cyc(1'b1, 1'b0, "R8");
        cmp("R8", "pulse on entry", sleep_pulse, 1'b1);
        cyc(1'b1, 1'b0, "R8");
        cyc(1'b0, 1'b0, "R10");
        for (int k = 0; k < W; k++) cyc(1'b0, 1'b0, "R10");
        cmp("R10", "ready after rewake", so_o, 1'b0);
      end
    end

    // strobes during the wake period and with chip select high
    cyc(1'b0, 1'b1, "R6");
    cyc(1'b1, 1'b0, "R8");
    cyc(1'b0, 1'b1, "R11");
    for (int k = 0; k < W; k++) cyc(1'b0, 1'b1, "R11");
    cyc(1'b1, 1'b0, "R11");
    cmp("R11", "still powered", reg_en, 1'b1);
    cyc(1'b1, 1'b1, "R11");
    cyc(1'b1, 1'b1, "R11");
    cyc(1'b1, 1'b0, "R11");
    cyc(1'b0, 1'b0, "R11");
    cmp("R11", "ready kept", so_o, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule